// File: doc/BRIEF.md
# Serial Configuration Memory Readout Sequencer

This block models the read side of a small serial memory that feeds a configuration bitstream to a programmable logic device, one bit per clock. Storage is a parameterized array of bytes. A synchronous write port loads it, and that port exists only for test. While the device is enabled, each rising clock edge shifts out the next bit, most significant bit of each byte first. The output changes just after the edge, so the receiving device samples it on the following rising edge. A separate output-enable qualifier tells the receiver when the data pin is being driven; when it is low, the pin counts as tri-stated.

Several devices can be chained. Each device has an active-low cascade output that goes low once its last bit has been presented. That output drives the chip enable of the next device, so the chain hands over with no gap and no overlap. Pulling the output-enable/reset input low rewinds a device to bit 0. After a rewind, the cascade output stays high until the whole array has been read out again. A ready output stays low for a fixed power-up interval after reset is released, and clocks are ignored until ready rises.

Top module: `cfgmem_reader`

## Requirements
- R1: `ready` is 0 while `rst` is high, and for the first 15 rising edges after `rst` falls. It becomes 1 on the 16th edge (`PWRUP_CYCLES`) and then stays 1 until the next reset.
- R2: Any edge that `ready` is 0 at presents no data and does not move the read position. The first enabled edge after `ready` rises presents stream bit 0.
- R3: An edge is a read edge when all of these hold at it: `ready` is 1, `ser_en` is 1, `ce_n` is 0, `oe_rst_n` is 1, and the last bit has not yet been presented. Each read edge sets `dout_en` to 1 and puts stream bit i on `dout`. Stream bit i is bit 7-(i mod 8) of the byte stored at address i/8, as written through `wr_en`/`wr_addr`/`wr_data`.
- R4: An edge with `ce_n` high sets `dout_en` to 0 and holds the read position. The next read edge continues with the following bit.
- R5: The read edge that presents the final bit (index `DEPTH_BYTES`*8-1) drives `cas_n` low. Later edges with `ce_n` low and `oe_rst_n` high keep `cas_n` low and `dout_en` low. The position does not wrap.
- R6: Once the final bit has been presented, and while `oe_rst_n` stays high, `cas_n` takes the value `ce_n` had at each edge.
- R7: An edge with `oe_rst_n` low sets `dout_en` to 0 and `cas_n` to 1 and returns the position to bit 0. After that, `cas_n` stays 1 whatever `ce_n` does, until the final bit is presented again.
- R8: While `ser_en` is 0, edges present no data and hold the read position, whatever `ce_n` is.
- R9: When the `cas_n` of one device drives the `ce_n` of a second, the second device presents its bit 0 on the edge right after the first device's final bit. Exactly one device drives data on each edge of the combined stream.
- R10: Right after reset, `dout_en` is 0, `cas_n` is 1 and `ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout and load clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_rst_n | input | 1 | Output enable; when low, rewinds the read position |
| ser_en | input | 1 | Serial enable; low selects programming mode |
| wr_en | input | 1 | Test load write strobe |
| wr_addr | input | ADDR_W | Test load byte address |
| wr_data | input | 8 | Test load byte |
| dout | output | 1 | Serial data bit |
| dout_en | output | 1 | High while `dout` is driven; low means tri-stated |
| cas_n | output | 1 | Active-low cascade enable for the next device |
| ready | output | 1 | High once the power-up interval has elapsed |

## Verification
The hardest condition to reach from the ports is the locked state of the cascade output: the final bit has been presented, `oe_rst_n` has then been pulsed low, and `ce_n` is toggled before the array is read again. Reaching it takes a complete readout of the first device, and in the chained bench also of the second. The stimulus therefore reads both arrays end to end, toggles `ce_n` to show the follow behaviour, pulses `oe_rst_n`, and toggles `ce_n` again to show that the output no longer follows. A partial read with a rewind part-way through, followed by a second complete chained read, checks that the rewind restarts at bit 0 and that the cascade output falls again only at the true end.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // bit lane inside a byte for a given position, most significant first
  function automatic logic [2:0] lane_of(input logic [2:0] pos);
    return 3'd7 - pos;
  endfunction
endpackage

// File: rtl/cfgmem_pwrup.sv
module cfgmem_pwrup #(
  parameter int PWRUP_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  localparam int PU_W = $clog2(PWRUP_CYCLES + 1);

  logic [PU_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == PU_W'(PWRUP_CYCLES - 1))
        ready <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgmem_store.sv
module cfgmem_store
  import cfgmem_pkg::*;
#(
  parameter int DEPTH_BYTES = 8,
  localparam int ADDR_W = $clog2(DEPTH_BYTES),
  localparam int BIT_W  = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  byte_t             wr_data,
  input  logic [BIT_W-1:0]  rd_pos,
  output logic              rd_bit
);
  byte_t mem [DEPTH_BYTES];
  byte_t rd_byte;

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_addr] <= wr_data;
  end

  always_comb begin
    rd_byte = mem[rd_pos[BIT_W-1:3]];
    rd_bit  = rd_byte[lane_of(rd_pos[2:0])];
  end
endmodule

// File: rtl/cfgmem_seq.sv
module cfgmem_seq #(
  parameter int DEPTH_BYTES = 8,
  localparam int BIT_W = $clog2(DEPTH_BYTES) + 3,
  localparam int LAST  = DEPTH_BYTES * 8 - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ready,
  input  logic             ce_n,
  input  logic             oe_rst_n,
  input  logic             ser_en,
  input  logic             rd_bit,
  output logic [BIT_W-1:0] rd_pos,
  output logic             dout,
  output logic             dout_en,
  output logic             cas_n
);
  logic spent;   // final bit already presented
  logic go;

  assign go = ready && ser_en && !ce_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pos  <= '0;
      spent   <= 1'b0;
      dout    <= 1'b0;
      dout_en <= 1'b0;
      cas_n   <= 1'b1;
    end else if (!oe_rst_n) begin
      rd_pos  <= '0;
      spent   <= 1'b0;
      dout_en <= 1'b0;
      cas_n   <= 1'b1;
    end else if (go && !spent) begin
      dout    <= rd_bit;
      dout_en <= 1'b1;
      if (rd_pos == BIT_W'(LAST)) begin
        spent <= 1'b1;
        cas_n <= 1'b0;
      end else begin
        rd_pos <= rd_pos + 1'b1;
      end
    end else begin
      dout_en <= 1'b0;
      cas_n   <= spent ? ce_n : 1'b1;
    end
  end
endmodule

// File: rtl/cfgmem_reader.sv
module cfgmem_reader
  import cfgmem_pkg::*;
#(
  parameter int DEPTH_BYTES  = 8,
  parameter int PWRUP_CYCLES = 16,
  localparam int ADDR_W = $clog2(DEPTH_BYTES),
  localparam int BIT_W  = ADDR_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_rst_n,
  input  logic              ser_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              dout,
  output logic              dout_en,
  output logic              cas_n,
  output logic              ready
);
  logic [BIT_W-1:0] rd_pos;
  logic             rd_bit;

  cfgmem_pwrup #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_pwrup (
    .clk(clk), .rst(rst), .ready(ready)
  );

  cfgmem_store #(.DEPTH_BYTES(DEPTH_BYTES)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_pos(rd_pos), .rd_bit(rd_bit)
  );

  cfgmem_seq #(.DEPTH_BYTES(DEPTH_BYTES)) u_seq (
    .clk(clk), .rst(rst), .ready(ready), .ce_n(ce_n), .oe_rst_n(oe_rst_n),
    .ser_en(ser_en), .rd_bit(rd_bit), .rd_pos(rd_pos), .dout(dout),
    .dout_en(dout_en), .cas_n(cas_n)
  );
endmodule

// File: rtl/cfgmem_reader_chk.sv
module cfgmem_reader_chk (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic oe_rst_n,
  input logic ser_en,
  input logic dout_en,
  input logic cas_n,
  input logic ready
);
  p_ready_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  p_quiet_before_ready_r2: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !dout_en);

  p_standby_r4: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !dout_en);

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && !ce_n && oe_rst_n) |=> (!cas_n && !dout_en));

  p_cas_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && oe_rst_n) |=> (cas_n == $past(ce_n)));

  p_rewind_r7: assert property (@(posedge clk) disable iff (rst)
    !oe_rst_n |=> (cas_n && !dout_en));

  p_prog_mode_r8: assert property (@(posedge clk) disable iff (rst)
    !ser_en |=> !dout_en);
endmodule

bind cfgmem_reader cfgmem_reader_chk u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_rst_n(oe_rst_n), .ser_en(ser_en),
  .dout_en(dout_en), .cas_n(cas_n), .ready(ready)
);

// File: tb/tb_cfgmem_reader.sv
module tb_cfgmem_reader;
  localparam int PERIOD = 10;
  localparam int DB     = 4;
  localparam int AW     = $clog2(DB);
  localparam int NBITS  = DB * 8;

  logic clk = 1'b0;
  logic rst, ce_n, oe_rst_n, ser_en;
  logic wr_en_a, wr_en_b;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic dout_a, en_a, cas_a, rdy_a;
  logic dout_b, en_b, cas_b, rdy_b;
  int total = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  cfgmem_reader #(.DEPTH_BYTES(DB), .PWRUP_CYCLES(16)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_rst_n(oe_rst_n), .ser_en(ser_en),
    .wr_en(wr_en_a), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout_a), .dout_en(en_a), .cas_n(cas_a), .ready(rdy_a));

  cfgmem_reader #(.DEPTH_BYTES(DB), .PWRUP_CYCLES(16)) dut_next (
    .clk(clk), .rst(rst), .ce_n(cas_a), .oe_rst_n(oe_rst_n), .ser_en(ser_en),
    .wr_en(wr_en_b), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout_b), .dout_en(en_b), .cas_n(cas_b), .ready(rdy_b));

  function automatic logic [7:0] pat(input int dev, input int a);
    return 8'((dev * 83 + a * 45 + 27) ^ (a << 3));
  endfunction

  function automatic logic exp_bit(input int i);
    logic [7:0] b;
    b = pat(i / NBITS, (i % NBITS) / 8);
    return b[7 - (i % 8)];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(PERIOD/4);
  endtask

  // one edge of the chained stream presenting combined bit i
  task automatic rd(input int i);
    tick();
    chk("R9 one driver", {30'd0, en_a, en_b}, (i < NBITS) ? 32'd2 : 32'd1);
    chk("R3 data bit", {31'd0, (en_a ? dout_a : dout_b)}, {31'd0, exp_bit(i)});
    chk("R5 cas first", {31'd0, cas_a}, {31'd0, (i < NBITS - 1)});
    chk("R9 cas second", {31'd0, cas_b}, {31'd0, (i < 2 * NBITS - 1)});
  endtask

  initial begin
    rst = 1'b1; ce_n = 1'b1; oe_rst_n = 1'b1; ser_en = 1'b1;
    wr_en_a = 1'b0; wr_en_b = 1'b0; wr_addr = '0; wr_data = '0;
    tick();
    for (int a = 0; a < DB; a++) begin
      wr_en_a = 1'b1; wr_en_b = 1'b1; wr_addr = AW'(a); wr_data = pat(0, a);
      tick();
      wr_en_b = 1'b0; wr_en_a = 1'b0;
      wr_data = pat(1, a); wr_en_b = 1'b1;
      tick();
      wr_en_b = 1'b0;
    end
    tick();
    chk("R10 ready", {31'd0, rdy_a}, 0);
    chk("R10 dout_en", {30'd0, en_a, en_b}, 0);
    chk("R10 cas", {30'd0, cas_a, cas_b}, 3);
    // R2: enabled clocks during the power-up interval are ignored
    rst = 1'b0; ce_n = 1'b0;
    for (int k = 1; k <= 15; k++) begin
      tick();
      chk("R1 ready low", {31'd0, rdy_a}, 0);
      chk("R2 no drive", {31'd0, en_a}, 0);
    end
    tick();
    chk("R1 ready rise", {30'd0, rdy_a, rdy_b}, 3);
    chk("R2 no drive", {31'd0, en_a}, 0);
    for (int i = 0; i < 10; i++) rd(i);
    // R4 standby
    ce_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R4 standby", {30'd0, en_a, en_b}, 0);
    end
    ce_n = 1'b0;
    rd(10);
    // R8 programming mode
    ser_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8 prog mode", {30'd0, en_a, en_b}, 0);
    end
    ser_en = 1'b1;
    for (int i = 11; i < 2 * NBITS; i++) rd(i);
    // R5 no wrap
    for (int k = 0; k < 2; k++) begin
      tick();
      chk("R5 idle at end", {30'd0, en_a, en_b}, 0);
      chk("R5 cas held", {30'd0, cas_a, cas_b}, 0);
    end
    // R6 follow
    ce_n = 1'b1;
    tick();
    chk("R6 follow high", {31'd0, cas_a}, 1);
    ce_n = 1'b0;
    tick();
    chk("R6 follow low", {31'd0, cas_a}, 0);
    chk("R5 still idle", {31'd0, en_a}, 0);
    // R7 rewind and lock
    oe_rst_n = 1'b0;
    tick();
    chk("R7 rewind", {29'd0, cas_a, cas_b, en_a}, 6);
    oe_rst_n = 1'b1; ce_n = 1'b1;
    tick();
    chk("R7 locked", {31'd0, cas_a}, 1);
    ce_n = 1'b0;
    for (int i = 0; i < 5; i++) rd(i);
    oe_rst_n = 1'b0;
    tick();
    chk("R7 mid rewind", {30'd0, cas_a, en_a}, 2);
    oe_rst_n = 1'b1;
    for (int i = 0; i < 2 * NBITS; i++) rd(i);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule